// File: doc/BRIEF.md
# Register Alias Table with Folded Condition Flags

This block is the renaming stage of a small out-of-order core in which every instruction writes exactly one result. Each renamed instruction gets a fresh physical register, taken from a free list, for its destination. If the instruction also produces condition flags, those flags are stored in spare upper bits of that same, wider physical register. The architectural flags alias is then pointed at it, so flags never need a renamed resource of their own.

Each cycle one rename request presents two source indices, one destination index and a flags-write bit. In the same cycle the block returns the physical indices of both sources, of the current flags holder and of the newly allocated destination. It also returns the destination's previous mapping, which the core carries to commit. A commit port hands that previous mapping back for reuse. If the returned register is still the flags holder, it is held back until the flags alias moves elsewhere. Because no instruction writes only part of a register, rename never has to merge a new result with an old physical value.

Top module: `fold_rename_table`

## Requirements
- R1: After reset, architectural register i maps to physical register i, the flags alias maps to physical register 0, and the free list holds physical registers ARCH_REGS up to PHYS_REGS-1 in ascending order.
- R2: Source and flags lookups are combinational from the current table. A source equal to the destination of the same request returns the mapping held before that request.
- R3: An accepted request receives the physical register at the head of the free list, in first-in first-out order. That register differs from both source mappings.
- R4: `ren_prev_phys` reports the destination's mapping before the request. After an accepted request, the destination maps to the allocated register.
- R5: An accepted request with `ren_wr_flags` high moves the flags alias to its allocated register. Any other cycle leaves the flags alias unchanged.
- R6: With the free list empty, `ren_ready` is low and a request is not accepted. The request changes neither the table, nor the flags alias, nor the free list.
- R7: A commit appends `cmt_phys` to the tail of the free list. It is allocated only after every register already in the list.
- R8: A commit of the register that is the current flags alias, in a cycle where the alias does not move, is deferred. The register enters the free list in the cycle a flags-writing request moves the alias off it. A commit that coincides with such a move is freed at once.
- R9: When a deferred flags register is released in the same cycle as a commit, the released register enters the free list ahead of the committed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | log2(ARCH_REGS) | First source architectural index |
| ren_src_b | input | log2(ARCH_REGS) | Second source architectural index |
| ren_dst | input | log2(ARCH_REGS) | Destination architectural index |
| ren_wr_flags | input | 1 | Request also produces condition flags |
| cmt_valid | input | 1 | A physical register is returned at commit |
| cmt_phys | input | log2(PHYS_REGS) | Physical register being returned |
| ren_ready | output | 1 | Free list not empty; request is accepted |
| ren_src_a_phys | output | log2(PHYS_REGS) | Physical mapping of first source |
| ren_src_b_phys | output | log2(PHYS_REGS) | Physical mapping of second source |
| ren_flags_phys | output | log2(PHYS_REGS) | Physical register holding current flags |
| ren_dst_phys | output | log2(PHYS_REGS) | Physical register allocated to destination |
| ren_prev_phys | output | log2(PHYS_REGS) | Previous mapping of the destination |

## Verification
The bench builds the block with its defaults of 16 architectural and 48 physical registers. That leaves 32 free entries, few enough that the free list can be drained to empty in a short run. This makes the stall, the allocation of a committed register after the whole original pool, and the deferred release of a pinned flags register all observable at the ports. With the list empty, each deferred or simultaneous free shows up as the very next allocation, so the ordering rules can be checked one register at a time.

// File: rtl/frt_pkg.sv
package frt_pkg;
    localparam int FRT_ARCH_REGS_DEFAULT = 16;
    localparam int FRT_PHYS_REGS_DEFAULT = 48;

    // Number of registers entering the free list in one cycle.
    function automatic int frt_push_count(input logic a, input logic b);
        return int'(a) + int'(b);
    endfunction
endpackage

// File: rtl/frt_free_fifo.sv
module frt_free_fifo #(
    parameter int ARCH_REGS = frt_pkg::FRT_ARCH_REGS_DEFAULT,
    parameter int PHYS_REGS = frt_pkg::FRT_PHYS_REGS_DEFAULT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pop,
    input  logic                         push0_valid,
    input  logic [$clog2(PHYS_REGS)-1:0] push0_idx,
    input  logic                         push1_valid,
    input  logic [$clog2(PHYS_REGS)-1:0] push1_idx,
    output logic [$clog2(PHYS_REGS)-1:0] head_idx,
    output logic                         empty
);
    localparam int PW    = $clog2(PHYS_REGS);
    localparam int DEPTH = PHYS_REGS;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int INIT  = PHYS_REGS - ARCH_REGS;

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [PW-1:0] mem_d [DEPTH];
    logic [PW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        logic [PW-1:0] wp;
        st_d  = st_q;
        mem_d = mem_q;
        wp    = st_q.tail;
        if (push0_valid) begin
            mem_d[wp] = push0_idx;
            wp        = wrap_inc(wp);
        end
        if (push1_valid) begin
            mem_d[wp] = push1_idx;
            wp        = wrap_inc(wp);
        end
        st_d.tail = wp;
        if (pop) st_d.head = wrap_inc(st_q.head);
        st_d.count = st_q.count + CW'(frt_pkg::frt_push_count(push0_valid, push1_valid))
                   - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.head  <= '0;
            st_q.tail  <= PW'(INIT);
            st_q.count <= CW'(INIT);
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= (i < INIT) ? PW'(ARCH_REGS + i) : '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign head_idx = mem_q[st_q.head];
    assign empty    = (st_q.count == '0);

    // R6
    pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.count != '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));
endmodule

// File: rtl/frt_map_table.sv
module frt_map_table #(
    parameter int ARCH_REGS = frt_pkg::FRT_ARCH_REGS_DEFAULT,
    parameter int PHYS_REGS = frt_pkg::FRT_PHYS_REGS_DEFAULT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(ARCH_REGS)-1:0] rd_a,
    input  logic [$clog2(ARCH_REGS)-1:0] rd_b,
    input  logic [$clog2(ARCH_REGS)-1:0] rd_dst,
    input  logic                         wr_en,
    input  logic                         wr_flags,
    input  logic [$clog2(PHYS_REGS)-1:0] wr_phys,
    output logic [$clog2(PHYS_REGS)-1:0] phys_a,
    output logic [$clog2(PHYS_REGS)-1:0] phys_b,
    output logic [$clog2(PHYS_REGS)-1:0] phys_dst_old,
    output logic [$clog2(PHYS_REGS)-1:0] phys_flags
);
    localparam int PW = $clog2(PHYS_REGS);

    logic [PW-1:0] map_d [ARCH_REGS];
    logic [PW-1:0] map_q [ARCH_REGS];
    logic [PW-1:0] flags_d, flags_q;

    always_comb begin
        map_d   = map_q;
        flags_d = flags_q;
        if (wr_en) begin
            map_d[rd_dst] = wr_phys;
            if (wr_flags) flags_d = wr_phys;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
            flags_q <= '0;
        end else begin
            map_q   <= map_d;
            flags_q <= flags_d;
        end
    end

    // Reads see the table as it stood before this cycle's write.
    assign phys_a       = map_q[rd_a];
    assign phys_b       = map_q[rd_b];
    assign phys_dst_old = map_q[rd_dst];
    assign phys_flags   = flags_q;

    // R4
    dst_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (phys_a == $past(wr_phys)) || (rd_a != $past(rd_dst)));

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_flags) |=> $stable(phys_flags));
endmodule

// File: rtl/frt_flag_hold.sv
module frt_flag_hold #(
    parameter int PHYS_REGS = frt_pkg::FRT_PHYS_REGS_DEFAULT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmt_valid,
    input  logic [$clog2(PHYS_REGS)-1:0] cmt_phys,
    input  logic [$clog2(PHYS_REGS)-1:0] flags_phys,
    input  logic                         flag_move,
    output logic                         rel_valid,
    output logic [$clog2(PHYS_REGS)-1:0] rel_phys,
    output logic                         dir_valid,
    output logic [$clog2(PHYS_REGS)-1:0] dir_phys
);
    logic [PHYS_REGS-1:0] pend_d, pend_q;
    logic                 hold;

    always_comb begin
        pend_d    = pend_q;
        rel_valid = flag_move && pend_q[flags_phys];
        rel_phys  = flags_phys;
        if (rel_valid) pend_d[flags_phys] = 1'b0;
        hold      = cmt_valid && (cmt_phys == flags_phys) && !flag_move;
        if (hold) pend_d[cmt_phys] = 1'b1;
        dir_valid = cmt_valid && !hold;
        dir_phys  = cmt_phys;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R8
    pending_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_q));

    // R8
    pending_is_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |-> pend_q[flags_phys]);
endmodule

// File: rtl/fold_rename_table.sv
module fold_rename_table #(
    parameter int ARCH_REGS = frt_pkg::FRT_ARCH_REGS_DEFAULT,
    parameter int PHYS_REGS = frt_pkg::FRT_PHYS_REGS_DEFAULT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ren_valid,
    input  logic [$clog2(ARCH_REGS)-1:0] ren_src_a,
    input  logic [$clog2(ARCH_REGS)-1:0] ren_src_b,
    input  logic [$clog2(ARCH_REGS)-1:0] ren_dst,
    input  logic                         ren_wr_flags,
    input  logic                         cmt_valid,
    input  logic [$clog2(PHYS_REGS)-1:0] cmt_phys,
    output logic                         ren_ready,
    output logic [$clog2(PHYS_REGS)-1:0] ren_src_a_phys,
    output logic [$clog2(PHYS_REGS)-1:0] ren_src_b_phys,
    output logic [$clog2(PHYS_REGS)-1:0] ren_flags_phys,
    output logic [$clog2(PHYS_REGS)-1:0] ren_dst_phys,
    output logic [$clog2(PHYS_REGS)-1:0] ren_prev_phys
);
    localparam int PW = $clog2(PHYS_REGS);

    logic          fl_empty;
    logic          fire;
    logic          flag_move;
    logic          rel_valid, dir_valid;
    logic [PW-1:0] rel_phys, dir_phys;

    assign ren_ready = !fl_empty;
    assign fire      = ren_valid && !fl_empty;
    assign flag_move = fire && ren_wr_flags;

    frt_free_fifo #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (fire),
        .push0_valid(rel_valid),
        .push0_idx  (rel_phys),
        .push1_valid(dir_valid),
        .push1_idx  (dir_phys),
        .head_idx   (ren_dst_phys),
        .empty      (fl_empty)
    );

    frt_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_a        (ren_src_a),
        .rd_b        (ren_src_b),
        .rd_dst      (ren_dst),
        .wr_en       (fire),
        .wr_flags    (ren_wr_flags),
        .wr_phys     (ren_dst_phys),
        .phys_a      (ren_src_a_phys),
        .phys_b      (ren_src_b_phys),
        .phys_dst_old(ren_prev_phys),
        .phys_flags  (ren_flags_phys)
    );

    frt_flag_hold #(.PHYS_REGS(PHYS_REGS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmt_valid (cmt_valid),
        .cmt_phys  (cmt_phys),
        .flags_phys(ren_flags_phys),
        .flag_move (flag_move),
        .rel_valid (rel_valid),
        .rel_phys  (rel_phys),
        .dir_valid (dir_valid),
        .dir_phys  (dir_phys)
    );

    // R3
    fresh_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (ren_dst_phys != ren_src_a_phys) && (ren_dst_phys != ren_src_b_phys)
                 && (ren_dst_phys != ren_prev_phys));

    // R5
    flags_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_move |=> (ren_flags_phys == $past(ren_dst_phys)));
endmodule

// File: tb/fold_rename_table_test.sv
module fold_rename_table_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0, ren_wr_flags = 1'b0, cmt_valid = 1'b0;
    logic [3:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic [5:0] cmt_phys = '0;
    logic       ren_ready;
    logic [5:0] ren_src_a_phys, ren_src_b_phys, ren_flags_phys, ren_dst_phys, ren_prev_phys;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    fold_rename_table uut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
        .ren_src_b(ren_src_b), .ren_dst(ren_dst), .ren_wr_flags(ren_wr_flags),
        .cmt_valid(cmt_valid), .cmt_phys(cmt_phys), .ren_ready(ren_ready),
        .ren_src_a_phys(ren_src_a_phys), .ren_src_b_phys(ren_src_b_phys),
        .ren_flags_phys(ren_flags_phys), .ren_dst_phys(ren_dst_phys),
        .ren_prev_phys(ren_prev_phys)
    );

    typedef struct packed {
        logic [3:0] a, b, d;
        logic       wf;
        logic [5:0] ea, eb, ef, ed, ep;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd1, 4'd2, 4'd3, 1'b0, 6'd1, 6'd2, 6'd0, 6'd16, 6'd3},
        '{4'd3, 4'd3, 4'd3, 1'b1, 6'd16, 6'd16, 6'd0, 6'd17, 6'd16},
        '{4'd3, 4'd0, 4'd5, 1'b0, 6'd17, 6'd0, 6'd17, 6'd18, 6'd5},
        '{4'd5, 4'd15, 4'd15, 1'b1, 6'd18, 6'd15, 6'd17, 6'd19, 6'd15},
        '{4'd15, 4'd3, 4'd0, 1'b0, 6'd19, 6'd17, 6'd19, 6'd20, 6'd0},
        '{4'd0, 4'd5, 4'd7, 1'b0, 6'd20, 6'd18, 6'd19, 6'd21, 6'd7}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, then settle before checks.
    task automatic setin(input logic v, input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] d, input logic wf,
                         input logic cv, input logic [5:0] cp);
        @(negedge clk);
        ren_valid = v; ren_src_a = a; ren_src_b = b; ren_dst = d;
        ren_wr_flags = wf; cmt_valid = cv; cmt_phys = cp;
        #2;
    endtask

    initial begin
        #(CLK_P * 5000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset mapping, flags alias and first free entry
        for (int i = 0; i < 16; i++) begin
            setin(1'b0, 4'(i), 4'(15 - i), 4'(i), 1'b0, 1'b0, 6'd0);
            check("R1 src_a", ren_src_a_phys, i);
            check("R1 src_b", ren_src_b_phys, 15 - i);
        end
        check("R1 flags", ren_flags_phys, 0);
        check("R1 head", ren_dst_phys, 16);
        check("R1 ready", ren_ready, 1);

        // R2 R3 R4 R5: vector walk
        for (int k = 0; k < 6; k++) begin
            setin(1'b1, VECS[k].a, VECS[k].b, VECS[k].d, VECS[k].wf, 1'b0, 6'd0);
            check("R2 src_a", ren_src_a_phys, VECS[k].ea);
            check("R2 src_b", ren_src_b_phys, VECS[k].eb);
            check("R5 flags", ren_flags_phys, VECS[k].ef);
            check("R3 dst", ren_dst_phys, VECS[k].ed);
            check("R4 prev", ren_prev_phys, VECS[k].ep);
        end

        // R7: return 3; R8: return current flags holder 19 (deferred)
        setin(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 6'd3);
        setin(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 6'd19);

        // R3: drain original pool in order
        for (int i = 0; i < 26; i++) begin
            setin(1'b1, 4'd0, 4'd0, 4'd1, 1'b0, 1'b0, 6'd0);
            check("R3 drain order", ren_dst_phys, 22 + i);
        end
        setin(1'b1, 4'd0, 4'd0, 4'd2, 1'b0, 1'b0, 6'd0);
        check("R7 committed after pool", ren_dst_phys, 3);
        check("R4 prev", ren_prev_phys, 2);

        // R6: empty list stalls a flags-writing request
        setin(1'b1, 4'd0, 4'd0, 4'd2, 1'b1, 1'b0, 6'd0);
        check("R6 ready low", ren_ready, 0);
        setin(1'b0, 4'd0, 4'd0, 4'd2, 1'b0, 1'b0, 6'd0);
        check("R6 table kept", ren_prev_phys, 3);
        check("R6 flags kept", ren_flags_phys, 19);
        check("R8 deferred not freed", ren_ready, 0);

        // R8: moving the alias releases 19
        setin(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 6'd5);
        setin(1'b1, 4'd0, 4'd0, 4'd4, 1'b1, 1'b0, 6'd0);
        check("R3 dst", ren_dst_phys, 5);
        setin(1'b1, 4'd0, 4'd0, 4'd6, 1'b0, 1'b0, 6'd0);
        check("R5 flags moved", ren_flags_phys, 5);
        check("R8 released", ren_dst_phys, 19);

        // R8: commit of flags holder coinciding with alias move frees at once
        setin(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 6'd15);
        setin(1'b1, 4'd0, 4'd0, 4'd9, 1'b1, 1'b1, 6'd5);
        check("R3 dst", ren_dst_phys, 15);
        setin(1'b1, 4'd0, 4'd0, 4'd11, 1'b0, 1'b0, 6'd0);
        check("R8 immediate free", ren_dst_phys, 5);
        check("R5 flags", ren_flags_phys, 15);

        // R9: release and commit in one cycle
        setin(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 6'd15);
        setin(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 6'd7);
        setin(1'b1, 4'd0, 4'd0, 4'd12, 1'b1, 1'b1, 6'd1);
        check("R3 dst", ren_dst_phys, 7);
        setin(1'b1, 4'd0, 4'd0, 4'd13, 1'b0, 1'b0, 6'd0);
        check("R9 released first", ren_dst_phys, 15);
        setin(1'b1, 4'd0, 4'd0, 4'd14, 1'b0, 1'b0, 6'd0);
        check("R9 commit second", ren_dst_phys, 1);
        setin(1'b0, 4'd0, 4'd0, 4'd14, 1'b0, 1'b0, 6'd0);
        check("R6 empty again", ren_ready, 0);
        check("R4 remap", ren_prev_phys, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule